// File: doc/BRIEF.md
# Mux-Adder Eight-Bit ALU

This block is a purely combinational arithmetic and logic unit for a small datapath in which every register load passes through the ALU. Two logic terms, the bitwise AND and the bitwise XOR of the operands, are formed first. Two 4:1 multiplexers then pick the two addends. A single adder sums the addends with a selected carry-in. The 4-bit operation code steers the multiplexers directly, with no decoder in between. As a result, all sixteen codes yield a defined value, including the ones that no instruction needs.

OR has no gate of its own. The block forms it as (A AND B) + (A XOR B), and this sum never carries because the two terms never share a set bit. Subtraction is A + ~B + 1. Pass-through of B lets unmodified data reach a register. The adder's carry out is dropped. An optional output register, enabled by a parameter, adds one cycle of latency. With the default setting the result settles in the same cycle as the inputs.

Top module: `mux_adder_alu`

## Requirements
- R1: op[1:0] selects the left addend: 00 = A AND B, 01 = A, 10 = zero, 11 = A XOR B.
- R2: op[3:2] selects the right addend and the carry-in: 00 = B with carry 0, 01 = ~B with carry 1, 10 = A XOR B with carry 0, 11 = zero with carry equal to op[0]. The result is (left + right + carry) modulo 2^WIDTH for every one of the 16 codes.
- R3: Code 0001 gives A + B modulo 2^WIDTH.
- R4: Code 0101 gives A - B modulo 2^WIDTH.
- R5: Code 1100 gives A AND B.
- R6: Code 1000 gives A OR B, obtained as the carry-free sum of the AND and XOR terms.
- R7: Code 1010 gives A XOR B.
- R8: Code 0010 gives B unchanged for any A.
- R9: Code 1101 gives A + 1, so 0xFF wraps to 0x00.
- R10: The side codes produce their datapath values: 1111 gives (A XOR B) + 1, 0110 gives the two's complement negation of B, and 1110 gives zero.
- R11: With OUT_REG = 0, y follows the inputs combinationally in the same cycle. With OUT_REG = 1, y takes the result at the next rising clock edge and is 0 while rst_n is low.
- R12: The adder's carry out is discarded. Sums that overflow wrap, with no other observable effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; used only by the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the optional output register |
| a | input | WIDTH | Operand A |
| b | input | WIDTH | Operand B |
| op | input | 4 | Operation code; bits [1:0] left addend, bits [3:2] right addend and carry |
| y | output | WIDTH | Result |

## Verification
On every clock edge, the bound checker compares the adder's result with the arithmetic or logical meaning of each named code: add, subtract, AND, OR, XOR, pass-B, increment and the (A XOR B) + 1 side product. The bench scenarios are needed for the rest. They cover the full 16-code table against an independent model, the wrap cases at 0x00, 0x7F/0x80 and 0xFF, and the zero code. They also show that the unregistered output changes within the same cycle, while the registered variant holds its old value until the next edge and clears under reset.

// File: rtl/mux_adder_alu.sv
module mux_adder_alu #(
  parameter int WIDTH   = 8,
  parameter bit OUT_REG = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [3:0]       op,
  output logic [WIDTH-1:0] y
);

  logic [WIDTH-1:0] t_and, t_xor, lhs, rhs, sum;
  logic             cin;

  assign t_and = a & b;
  assign t_xor = a ^ b;

  always_comb begin
    case (op[1:0])
      2'b00:   lhs = t_and;
      2'b01:   lhs = a;
      2'b10:   lhs = '0;
      default: lhs = t_xor;
    endcase
  end

  always_comb begin
    case (op[3:2])
      2'b00:   begin rhs = b;     cin = 1'b0;  end
      2'b01:   begin rhs = ~b;    cin = 1'b1;  end
      2'b10:   begin rhs = t_xor; cin = 1'b0;  end
      default: begin rhs = '0;    cin = op[0]; end
    endcase
  end

  assign sum = lhs + rhs + {{(WIDTH-1){1'b0}}, cin};

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) y <= '0;
        else        y <= sum;
      end
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign y = sum;
    end
  endgenerate

endmodule

// File: rtl/mux_adder_alu_chk.sv
module mux_adder_alu_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic [3:0]       op,
  input logic [WIDTH-1:0] sum
);

  p_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op == 4'b0001 |-> sum == WIDTH'(a + b));

  p_sub_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op == 4'b0101 |-> sum == WIDTH'(a - b));

  p_and_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op == 4'b1100 |-> sum == (a & b));

  p_or_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op == 4'b1000 |-> sum == (a | b));

  p_xor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op == 4'b1010 |-> sum == (a ^ b));

  p_passb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op == 4'b0010 |-> sum == b);

  p_inc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op == 4'b1101 |-> sum == WIDTH'(a + 1'b1));

  p_xorinc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    op == 4'b1111 |-> sum == WIDTH'((a ^ b) + 1'b1));

endmodule

bind mux_adder_alu mux_adder_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .a(a), .b(b), .op(op), .sum(sum)
);

// File: tb/tb_mux_adder_alu.sv
module tb_mux_adder_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] a = '0, b = '0;
  logic [3:0] op = '0;
  logic [7:0] y, y_reg;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  mux_adder_alu #(.WIDTH(8), .OUT_REG(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .op(op), .y(y));
  mux_adder_alu #(.WIDTH(8), .OUT_REG(1'b1)) dut_reg (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .op(op), .y(y_reg));

  function automatic logic [7:0] ref_model(logic [3:0] c, logic [7:0] x, logic [7:0] z);
    logic [7:0] l, r;
    logic       ci;
    case (c[1:0])
      2'b00: l = x & z;
      2'b01: l = x;
      2'b10: l = 8'h00;
      default: l = x ^ z;
    endcase
    case (c[3:2])
      2'b00: begin r = z;     ci = 1'b0; end
      2'b01: begin r = ~z;    ci = 1'b1; end
      2'b10: begin r = x ^ z; ci = 1'b0; end
      default: begin r = 8'h00; ci = c[0]; end
    endcase
    return 8'(l + r + {7'd0, ci});
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s op=%b a=%h b=%h got=%h exp=%h", tag, op, a, b, got, exp);
    end
  endtask

  task automatic apply(logic [3:0] c, logic [7:0] x, logic [7:0] z);
    @(negedge clk);
    op = c; a = x; b = z;
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    apply(4'b0001, 8'h12, 8'h34);
    check("R11 reset reg out", y_reg, 8'h00);
    check("R11 comb during reset", y, 8'h46);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_table();
    logic [7:0] edges [3] = '{8'h00, 8'hFF, 8'h80};
    for (int c = 0; c < 16; c++) begin
      for (int i = 0; i < 3; i++)
        for (int j = 0; j < 3; j++) begin
          apply(4'(c), edges[i], edges[j]);
          check("R1 R2 table edge", y, ref_model(4'(c), edges[i], edges[j]));
        end
      for (int k = 0; k < 8; k++) begin
        apply(4'(c), 8'($urandom), 8'($urandom));
        check("R1 R2 table random", y, ref_model(op, a, b));
      end
    end
  endtask

  task automatic t_named();
    apply(4'b0001, 8'h3C, 8'h21); check("R3 add", y, 8'h5D);
    apply(4'b0001, 8'hFF, 8'h01); check("R12 add wrap", y, 8'h00);
    apply(4'b0001, 8'h80, 8'h80); check("R12 add wrap 80", y, 8'h00);
    apply(4'b0101, 8'h50, 8'h20); check("R4 sub", y, 8'h30);
    apply(4'b0101, 8'h00, 8'h01); check("R4 sub borrow", y, 8'hFF);
    apply(4'b0101, 8'h80, 8'h7F); check("R4 sub 80-7F", y, 8'h01);
    apply(4'b1100, 8'hF0, 8'h3C); check("R5 and", y, 8'h30);
    apply(4'b1000, 8'hF0, 8'h3C); check("R6 or", y, 8'hFC);
    apply(4'b1000, 8'hFF, 8'hFF); check("R6 or all ones", y, 8'hFF);
    apply(4'b1010, 8'hF0, 8'h3C); check("R7 xor", y, 8'hCC);
    apply(4'b0010, 8'hA5, 8'h5A); check("R8 pass b", y, 8'h5A);
    apply(4'b0010, 8'hFF, 8'h00); check("R8 pass b zero", y, 8'h00);
    apply(4'b1101, 8'h7F, 8'h00); check("R9 inc", y, 8'h80);
    apply(4'b1101, 8'hFF, 8'h55); check("R9 inc wrap", y, 8'h00);
  endtask

  task automatic t_side();
    apply(4'b1111, 8'h0F, 8'h0F); check("R10 xor plus one", y, 8'h01);
    apply(4'b1111, 8'hFF, 8'h00); check("R10 xor plus one wrap", y, 8'h00);
    apply(4'b0110, 8'h99, 8'h01); check("R10 negate b", y, 8'hFF);
    apply(4'b0110, 8'h99, 8'h80); check("R10 negate 80", y, 8'h80);
    apply(4'b1110, 8'hFF, 8'hFF); check("R10 zero code", y, 8'h00);
  endtask

  task automatic t_latency();
    apply(4'b0001, 8'h01, 8'h02);
    @(posedge clk); #1;
    check("R11 reg settles", y_reg, 8'h03);
    apply(4'b0001, 8'h10, 8'h20);
    check("R11 comb same cycle", y, 8'h30);
    check("R11 reg holds before edge", y_reg, 8'h03);
    @(posedge clk); #1;
    check("R11 reg after edge", y_reg, 8'h30);
  endtask

  initial begin
    t_reset();
    t_named();
    t_side();
    t_table();
    t_latency();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired R1 got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule